// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder (64 lines)

This block turns 64 active-low request lines into the 6-bit active-low index of the highest-numbered active line. It is built from eight identical 8-line encoder units. Each unit reports the position of its highest active input as a 3-bit active-low code. It also has a group-active flag and an enable input/output pair.

The units are chained through their enables, from the unit holding lines 63..56 down to the unit holding lines 7..0. A unit with an active line therefore blocks every unit below it. The 3-bit code drivers of all units share one low-order bus. Each driver carries an explicit output enable, and a resolution stage with a pull-up model merges them onto that bus. The upper three code bits are the active-low number of the unit whose group flag is low.

The behaviour is purely combinational. A host drives `en_n` low to enable the whole chain and reads `code_n` while `gs_n` is low. `eo_n` can feed a further stage.

Top module: `prienc64_cascade`

## Requirements
- R1: Within a unit, the highest-numbered low input sets the code, and lower inputs are ignored. The code is active low with bit 0 as its LSB. In unit 0, line 7 low gives `code_n[2:0]` = 3'b000, and line 0 alone gives 3'b111.
- R2: With `en_n` low and only lines 1, 2 and 4 low, `code_n` = 6'b111011. This is binary 4 inverted in the low bits, with unit 0 inverted in the high bits.
- R3: With `en_n` low and at least one line low, `code_n` equals the bitwise inverse of the index (0..63) of the highest-numbered low line. `code_n[5:3]` is the inverted unit number.
- R4: With `en_n` low and at least one line low, `gs_n` = 0 and `eo_n` = 1.
- R5: With `en_n` high, `code_n` = 6'b111111, `gs_n` = 1 and `eo_n` = 1, whatever the request lines are.
- R6: With `en_n` low and all 64 lines high, `code_n` = 6'b111111, `gs_n` = 1 and `eo_n` = 0.
- R7: At most one unit enables its code driver at a time, and it is the unit holding the highest active line. Active lines in lower units never change `code_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable for the whole chain |
| req_n | input | 64 | Active-low request lines; line 63 has top priority |
| code_n | output | 6 | Active-low index of the highest active line |
| gs_n | output | 1 | Low when any line is active and the chain is enabled |
| eo_n | output | 1 | Low when enabled and no line is active |

## Verification
The bench goes after the places where two active lines compete, within one unit and across units. If the enable chain were broken or reversed, a lower unit would also drive the shared bus, and the wired resolution would then corrupt the low code bits. Line 0 alone and the all-idle case give the same code and differ only in `gs_n` and `eo_n`. A design that mixed up the two flags or their polarity would fail one of those two cases. Vectors with `en_n` high and many active lines catch a design that lets data reach the code, or the group flag, while it is disabled.

// File: rtl/penc_pkg.sv
package penc_pkg;

    localparam int DEF_UNITS = 8;
    localparam int DEF_LINES = 8;

    // Operating condition of one encoder unit.
    typedef enum logic [1:0] {
        U_OFF  = 2'd0,   // enable input inactive
        U_IDLE = 2'd1,   // enabled, no active request
        U_HIT  = 2'd2    // enabled, at least one active request
    } unit_mode_e;

endpackage

// File: rtl/penc_unit.sv
module penc_unit
    import penc_pkg::*;
#(
    parameter  int LINES = DEF_LINES,
    localparam int CW    = $clog2(LINES)
) (
    input  logic             ei_n,
    input  logic [LINES-1:0] req_n,
    output logic [CW-1:0]    code_n,
    output logic             code_oe,
    output logic             gs_n,
    output logic             eo_n
);

    typedef struct packed {
        logic [CW-1:0] code_n;
        logic          oe;
        logic          gs_n;
        logic          eo_n;
    } unit_res_t;

    unit_mode_e    mode_d;
    logic [CW-1:0] top_idx_d;
    unit_res_t     res_d;

    // Highest-numbered low input; later iterations override earlier ones.
    always_comb begin
        top_idx_d = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!req_n[i]) top_idx_d = CW'(i);
        end
    end

    always_comb begin
        if (ei_n)          mode_d = U_OFF;
        else if (&req_n)   mode_d = U_IDLE;
        else               mode_d = U_HIT;
    end

    always_comb begin
        res_d = '{code_n: '1, oe: 1'b0, gs_n: 1'b1, eo_n: 1'b1};
        case (mode_d)
            U_IDLE: res_d.eo_n = 1'b0;
            U_HIT: begin
                res_d.code_n = ~top_idx_d;
                res_d.oe     = 1'b1;
                res_d.gs_n   = 1'b0;
            end
            default: ;
        endcase
    end

    assign code_n  = res_d.code_n;
    assign code_oe = res_d.oe;
    assign gs_n    = res_d.gs_n;
    assign eo_n    = res_d.eo_n;

endmodule

// File: rtl/penc_bus_pullup.sv
module penc_bus_pullup #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0]   oe,
    input  logic [N*W-1:0] drv,
    output logic [W-1:0]   bus
);

    // Resolved shared bus: released drivers leave the pull-up level (all ones);
    // an enabled driver pulls bits low where its value is zero.
    always_comb begin
        bus = '1;
        for (int u = 0; u < N; u++) begin
            if (oe[u]) bus = bus & drv[u*W +: W];
        end
    end

endmodule

// File: rtl/penc_group_index.sv
module penc_group_index #(
    parameter  int N  = 8,
    localparam int GW = $clog2(N)
) (
    input  logic [N-1:0]  grp_n,
    output logic [GW-1:0] idx_n
);

    // Bit b goes low when an active unit has bit b set in its number.
    always_comb begin
        idx_n = '1;
        for (int u = 0; u < N; u++) begin
            if (!grp_n[u]) idx_n = idx_n & ~GW'(u);
        end
    end

endmodule

// File: rtl/prienc64_cascade.sv
module prienc64_cascade
    import penc_pkg::*;
#(
    parameter  int N_UNITS    = DEF_UNITS,
    parameter  int UNIT_LINES = DEF_LINES,
    localparam int CW         = $clog2(UNIT_LINES),
    localparam int GW         = $clog2(N_UNITS),
    localparam int TOTAL      = N_UNITS * UNIT_LINES
) (
    input  logic             en_n,
    input  logic [TOTAL-1:0] req_n,
    output logic [GW+CW-1:0] code_n,
    output logic             gs_n,
    output logic             eo_n
);

    logic [N_UNITS-1:0]    unit_ei_n;
    logic [N_UNITS-1:0]    unit_eo_n;
    logic [N_UNITS-1:0]    unit_gs_n;
    logic [N_UNITS-1:0]    unit_oe;
    logic [N_UNITS*CW-1:0] unit_code_n;
    logic [CW-1:0]         low_bus;
    logic [GW-1:0]         grp_idx_n;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        // Enable flows from the highest group downward.
        if (u == N_UNITS - 1) begin : g_head
            assign unit_ei_n[u] = en_n;
        end else begin : g_link
            assign unit_ei_n[u] = unit_eo_n[u+1];
        end

        penc_unit #(.LINES(UNIT_LINES)) i_unit (
            .ei_n    (unit_ei_n[u]),
            .req_n   (req_n[u*UNIT_LINES +: UNIT_LINES]),
            .code_n  (unit_code_n[u*CW +: CW]),
            .code_oe (unit_oe[u]),
            .gs_n    (unit_gs_n[u]),
            .eo_n    (unit_eo_n[u])
        );
    end

    penc_bus_pullup #(.N(N_UNITS), .W(CW)) i_bus (
        .oe  (unit_oe),
        .drv (unit_code_n),
        .bus (low_bus)
    );

    penc_group_index #(.N(N_UNITS)) i_gidx (
        .grp_n (unit_gs_n),
        .idx_n (grp_idx_n)
    );

    assign code_n = {grp_idx_n, low_bus};
    assign gs_n   = &unit_gs_n;
    assign eo_n   = unit_eo_n[0];

endmodule

// File: rtl/penc_cascade_chk.sv
module penc_cascade_chk #(
    parameter  int N_UNITS    = 8,
    parameter  int UNIT_LINES = 8,
    localparam int CW         = $clog2(UNIT_LINES),
    localparam int GW         = $clog2(N_UNITS),
    localparam int TOTAL      = N_UNITS * UNIT_LINES
) (
    input logic             en_n,
    input logic [TOTAL-1:0] req_n,
    input logic [GW+CW-1:0] code_n,
    input logic             gs_n,
    input logic             eo_n,
    input logic [N_UNITS-1:0] unit_oe,
    input logic [N_UNITS-1:0] unit_gs_n
);

    always_comb begin
        AST_SINGLE_DRIVER: assert ($countones(unit_oe) <= 1)
            else $error("more than one unit drives the shared bus"); // R7
        AST_DRIVER_MATCHES_GROUP: assert ((unit_oe != '0) == !gs_n)
            else $error("bus driver presence disagrees with group flag"); // R7
        if (en_n) begin
            AST_DISABLED_OUT: assert (gs_n && eo_n && (&code_n))
                else $error("outputs not idle while disabled"); // R5
        end
        if (!en_n && (&req_n)) begin
            AST_IDLE_OUT: assert (gs_n && !eo_n && (&code_n))
                else $error("idle chain outputs wrong"); // R6
        end
        if (!en_n && !(&req_n)) begin
            AST_ACTIVE_FLAGS: assert (!gs_n && eo_n)
                else $error("active chain flags wrong"); // R4
        end
    end

endmodule

bind prienc64_cascade penc_cascade_chk #(
    .N_UNITS    (N_UNITS),
    .UNIT_LINES (UNIT_LINES)
) i_chk (
    .en_n      (en_n),
    .req_n     (req_n),
    .code_n    (code_n),
    .gs_n      (gs_n),
    .eo_n      (eo_n),
    .unit_oe   (unit_oe),
    .unit_gs_n (unit_gs_n)
);

// File: tb/test_prienc64_cascade.sv
module test_prienc64_cascade;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b1;
    logic [63:0] req_n = '1;
    logic [5:0]  code_n;
    logic        gs_n;
    logic        eo_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    prienc64_cascade i_prienc64_cascade (
        .en_n   (en_n),
        .req_n  (req_n),
        .code_n (code_n),
        .gs_n   (gs_n),
        .eo_n   (eo_n)
    );

    // vector: {tag[2:0], en_n, req_n[63:0], code_n[5:0], gs_n, eo_n}
    localparam int NV = 10;
    localparam logic [75:0] VECS [NV] = '{
        {3'd5, 1'b1, 64'h0,                            6'h3f,      1'b1, 1'b1},
        {3'd6, 1'b0, {64{1'b1}},                       6'h3f,      1'b1, 1'b0},
        {3'd1, 1'b0, ~(64'd1 << 63),                   6'b000000,  1'b0, 1'b1},
        {3'd1, 1'b0, ~64'd1,                           6'b111111,  1'b0, 1'b1},
        {3'd2, 1'b0, ~(64'h2 | 64'h4 | 64'h10),        6'b111011,  1'b0, 1'b1},
        {3'd1, 1'b0, ~(64'h80 | 64'h1),                6'b111000,  1'b0, 1'b1},
        {3'd3, 1'b0, ~(64'd1 << 8),                    6'b110111,  1'b0, 1'b1},
        {3'd7, 1'b0, ~((64'd1 << 63) | 64'd1),         6'b000000,  1'b0, 1'b1},
        {3'd3, 1'b0, ~((64'd1 << 35) | (64'd1 << 20)), 6'b011100,  1'b0, 1'b1},
        {3'd5, 1'b1, ~(64'd1 << 5),                    6'h3f,      1'b1, 1'b1}
    };

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference model from the requirements: {code_n, gs_n, eo_n}.
    function automatic logic [7:0] ref_out(input logic e, input logic [63:0] r);
        logic [5:0] idx;
        if (e) return {6'h3f, 1'b1, 1'b1};
        if (&r) return {6'h3f, 1'b1, 1'b0};
        idx = '0;
        for (int i = 0; i < 64; i++) if (!r[i]) idx = 6'(i);
        return {~idx, 1'b0, 1'b1};
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {code_n, gs_n, eo_n};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s en_n=%b req_n=%h got {code,gs,eo}=%h want %h",
                     req, en_n, req_n, act, exp);
        end
    endtask

    task automatic apply(input logic e, input logic [63:0] r, input string req,
                         input logic [7:0] exp);
        @(negedge clk);
        en_n  = e;
        req_n = r;
        @(posedge clk);
        #1;
        check(req, exp);
    endtask

    initial begin
        // Reset phase: chain disabled, outputs must be idle (R5).
        repeat (3) @(posedge clk);
        #1;
        check("R5", {6'h3f, 1'b1, 1'b1});
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v][72], VECS[v][71:8], tag_name(VECS[v][75:73]), VECS[v][7:0]);
        end

        // R3: walk a single active line across all 64 positions.
        for (int k = 0; k < 64; k++) begin
            apply(1'b0, ~(64'd1 << k), "R3", ref_out(1'b0, ~(64'd1 << k)));
        end

        // R7: two active lines spread over different units.
        for (int k = 0; k < 64; k++) begin
            logic [63:0] p;
            p = ~((64'd1 << k) | (64'd1 << ((k * 37 + 11) % 64)));
            apply(1'b0, p, "R7", ref_out(1'b0, p));
        end

        // R4: dense patterns, many lines active at once.
        for (int k = 0; k < 16; k++) begin
            logic [63:0] p;
            p = {64{1'b1}} >> (k * 4 + 1);
            apply(1'b0, p, "R4", ref_out(1'b0, p));
        end

        // R5: disabled chain with assorted requests.
        for (int k = 0; k < 16; k++) begin
            logic [63:0] p;
            p = 64'h5a5a_3c3c_0f0f_9669 ^ (64'hffff << (k * 3));
            apply(1'b1, p, "R5", {6'h3f, 1'b1, 1'b1});
        end

        // R6: return to idle after activity.
        apply(1'b0, {64{1'b1}}, "R6", {6'h3f, 1'b1, 1'b0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, got timeout want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule